// File: doc/BRIEF.md
# AES Round Sequencing Controller

This block is the control state machine of an iterative AES cipher datapath. It takes one block over a valid/ready input handshake. It then steps through the initial key addition, the middle rounds and the final round by driving the source selects and write enables of the state register, the full-key register and the decryption-key register. It also drives the add-round-key input select, the round-key word select and the inverse-MixColumns round-key option. A multi-cycle SubBytes unit and a key-expansion unit are paced through enable/request/acknowledge triples. The final round result is never stored: it leaves the datapath combinationally while output valid is high. In the same cycle as the output transfer, the state register is overwritten with clearing data.

The controller has a second mode that produces the start key for decryption. In this mode it runs only the forward key schedule, writes the last expanded key into the decryption-key register and returns to idle without presenting any output. The controller captures the operation, the key length and the mode when it accepts a block. A corrupted select or enable, reported by the datapath checkers on `sel_fault`, locks the controller into a terminal error state. An illegal configuration at acceptance does the same.

The states are IDLE, INIT, ROUND, FINAL and ERROR. IDLE moves to INIT on acceptance, or to ERROR on a bad configuration. INIT moves to ROUND after one cycle for a 256-bit key, or after the key-expansion handshake otherwise. ROUND repeats until the last middle round. It then moves to FINAL in cipher mode, or back to IDLE in key-generation mode. FINAL moves to IDLE on the output transfer. Any state moves to ERROR on `sel_fault`, and ERROR is left only by reset.

Top module: `aes_round_seq`

## Requirements
- R1: After reset the controller is idle: `in_ready`=1, `out_valid`=0, `alert`=0, no write enable. `in_ready` is high only in IDLE and drops in the cycle after a block is accepted.
- R2: The round count N is 10, 12 or 14 for `key_len` 0, 1 or 2. A cipher block makes one state write with `state_sel`=1 (round result) and `ark_sel`=0 (held state), then N-1 state writes with `state_sel`=1 and `ark_sel`=1 (MixColumns output). The final round drives `ark_sel`=2 (ShiftRows output) and never writes round data.
- R3: `kword_sel` (0 words 0-3, 1 words 2-5, 2 words 4-7, 3 zero) in the initial step is 0 for forward operation and for 128-bit keys. It is 1 for inverse 192 and 2 for inverse 256. In middle and final rounds it is 0 for 128-bit keys, 1 for forward 192, 2 for forward 256 and 0 for inverse 192/256.
- R4: `rkey_mix` is high on the N-1 middle-round state writes of an inverse operation, and on no state write of a forward operation.
- R5: With a 256-bit key, INIT lasts one cycle and does not enable key expansion. The full key is written 1+1+(N-1) times per block for 128/192-bit keys and 1+(N-1) times for 256-bit keys.
- R6: A round completes only when SubBytes (`sb_req`) and key expansion (`kexp_req`) both request. Their acknowledges are given only while the matching enable and request are high. The round structure does not depend on their latency.
- R7: In FINAL, `out_valid` follows the SubBytes request and stays high until `out_ready`. On the transfer, the state register is written with `state_sel`=2 (clear data) and the controller returns to IDLE.
- R8: With `keygen`=1, no state write occurs, `out_valid` stays low and `kword_sel` is 3. `dkey_we` pulses once at the end of the last middle round, and the controller returns to IDLE.
- R9: `op_sel` must be 2'b01 (forward) or 2'b10 (inverse), and `key_len` must not be 3. A block accepted with another value causes no write and enters ERROR. The configuration is held from acceptance, so input changes while busy have no effect.
- R10: While `sel_fault` is high, `out_valid`, `in_ready` and all write enables are low in that same cycle. The next state is ERROR, where `alert` stays high and `in_ready` low until reset.
- R11: `prng_upd` pulses at acceptance and at the completion of the initial step and of each middle round: N+1 pulses per block.
- R12: At acceptance the full-key source is `fkey_sel`=0 (encryption key) for forward and key-generation operations, and 1 (stored decryption key) for inverse operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Ready to accept a block (IDLE only) |
| op_sel | input | 2 | 01 forward, 10 inverse |
| key_len | input | 2 | 0: 128, 1: 192, 2: 256-bit key |
| keygen | input | 1 | Decryption start-key generation mode |
| out_valid | output | 1 | Final result valid on the datapath output |
| out_ready | input | 1 | Output consumer ready |
| sb_en | output | 1 | SubBytes enable |
| sb_req | input | 1 | SubBytes result request |
| sb_ack | output | 1 | SubBytes result acknowledge |
| kexp_en | output | 1 | Key expansion enable |
| kexp_req | input | 1 | Key expansion result request |
| kexp_ack | output | 1 | Key expansion result acknowledge |
| kexp_inv | output | 1 | Key schedule runs backwards |
| kexp_round | output | RND_W | Current round number |
| state_sel | output | 2 | State source: 0 input, 1 round result, 2 clear data |
| state_we | output | 1 | State register write enable |
| ark_sel | output | 2 | Add-round-key input: 0 held, 1 MixColumns, 2 ShiftRows |
| fkey_sel | output | 2 | Full-key source: 0 enc key, 1 dec key, 2 expansion, 3 clear |
| fkey_we | output | 1 | Full-key register write enable |
| dkey_we | output | 1 | Decryption-key register write enable |
| kword_sel | output | 2 | Round-key words: 0 w0-3, 1 w2-5, 2 w4-7, 3 zero |
| rkey_mix | output | 1 | Pass the round key through inverse MixColumns |
| prng_upd | output | 1 | Advance the masking PRNG |
| sel_fault | input | 1 | Corrupted select or enable detected |
| alert | output | 1 | Terminal error alert |

## Verification
The bench runs blocks of all three key lengths in both directions, with SubBytes latencies of 1 and 5 cycles and varied output back-pressure. A wrong round limit or a miscounted INIT step then shows up as a changed number of initial, middle or key writes. Swapping the 192/256 inverse word rows or forgetting the inverse key mix shows up in `kword_sel` and `rkey_mix`. A controller that drops `out_valid` early or skips the wipe is caught at the transfer. Key-generation runs check that no state write or output escapes and that exactly one decryption-key write occurs. Directed cases inject an illegal operation and key length at acceptance and a fault during a stalled final round; a design that released data in the fault cycle or let `alert` fall would fail there.

// File: rtl/aes_seq_pkg.sv
package aes_seq_pkg;

    localparam logic [1:0] OP_FWD  = 2'b01;
    localparam logic [1:0] OP_INV  = 2'b10;
    localparam logic [1:0] KL_128  = 2'd0;
    localparam logic [1:0] KL_192  = 2'd1;
    localparam logic [1:0] KL_256  = 2'd2;
    localparam logic [1:0] KL_BAD  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INIT  = 3'd1,
        ST_ROUND = 3'd2,
        ST_FINAL = 3'd3,
        ST_ERROR = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        SSEL_INPUT = 2'd0,
        SSEL_ROUND = 2'd1,
        SSEL_CLEAR = 2'd2
    } state_src_e;

    typedef enum logic [1:0] {
        ARK_HELD    = 2'd0,
        ARK_MIXED   = 2'd1,
        ARK_SHIFTED = 2'd2
    } ark_src_e;

    typedef enum logic [1:0] {
        FK_ENC_INIT = 2'd0,
        FK_DEC_INIT = 2'd1,
        FK_EXPAND   = 2'd2,
        FK_CLEAR    = 2'd3
    } fkey_src_e;

    typedef enum logic [1:0] {
        KW_LOW  = 2'd0,
        KW_MID  = 2'd1,
        KW_HIGH = 2'd2,
        KW_ZERO = 2'd3
    } kword_e;

    typedef enum logic [1:0] {
        PH_FIRST = 2'd0,
        PH_MID   = 2'd1,
        PH_LAST  = 2'd2
    } phase_e;

    function automatic int unsigned rounds_for(input logic [1:0] kl);
        case (kl)
            KL_192:  return 12;
            KL_256:  return 14;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/aes_seq_rnd_ctr.sv
module aes_seq_rnd_ctr
    import aes_seq_pkg::*;
#(
    parameter int RND_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [1:0]       klen,
    output logic [RND_W-1:0] rnd,
    output logic             at_last_mid
);
    logic [RND_W-1:0] rnd_q;
    logic [RND_W-1:0] last_mid;

    always_comb begin
        last_mid = RND_W'(rounds_for(klen) - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_q <= '0;
        end else if (clr) begin
            rnd_q <= '0;
        end else if (inc) begin
            rnd_q <= rnd_q + 1'b1;
        end
    end

    assign rnd         = rnd_q;
    assign at_last_mid = (rnd_q == last_mid);
endmodule

// File: rtl/aes_seq_sel_map.sv
module aes_seq_sel_map
    import aes_seq_pkg::*;
(
    input  phase_e     phase,
    input  logic       inv,
    input  logic       keygen,
    input  logic [1:0] klen,
    output kword_e     kword,
    output ark_src_e   ark,
    output logic       rkey_mix
);
    always_comb begin
        kword = KW_LOW;
        if (keygen) begin
            kword = KW_ZERO;
        end else if (phase == PH_FIRST) begin
            unique case (klen)
                KL_192:  kword = inv ? KW_MID  : KW_LOW;
                KL_256:  kword = inv ? KW_HIGH : KW_LOW;
                default: kword = KW_LOW;
            endcase
        end else begin
            unique case (klen)
                KL_192:  kword = inv ? KW_LOW : KW_MID;
                KL_256:  kword = inv ? KW_LOW : KW_HIGH;
                default: kword = KW_LOW;
            endcase
        end
    end

    always_comb begin
        unique case (phase)
            PH_FIRST: ark = ARK_HELD;
            PH_MID:   ark = ARK_MIXED;
            PH_LAST:  ark = ARK_SHIFTED;
            default:  ark = ARK_HELD;
        endcase
    end

    assign rkey_mix = (phase == PH_MID) && inv && !keygen;
endmodule

// File: rtl/aes_seq_fsm.sv
module aes_seq_fsm
    import aes_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [1:0] op_sel,
    input  logic [1:0] key_len,
    input  logic       keygen,
    input  logic       out_ready,
    input  logic       sb_req,
    input  logic       kexp_req,
    input  logic       sel_fault,
    input  logic       at_last_mid,
    output logic       in_ready,
    output logic       out_valid,
    output logic       alert,
    output logic       sb_en,
    output logic       sb_ack,
    output logic       kexp_en,
    output logic       kexp_ack,
    output logic       state_we,
    output state_src_e state_sel,
    output logic       fkey_we,
    output fkey_src_e  fkey_sel,
    output logic       dkey_we,
    output logic       prng_upd,
    output logic       rnd_clr,
    output logic       rnd_inc,
    output phase_e     phase,
    output logic       inv_q,
    output logic       keygen_q,
    output logic [1:0] klen_q
);
    seq_state_e st_q, st_d;
    logic       cfg_ok;
    logic       cfg_load;
    logic       step;

    assign cfg_ok = ((op_sel == OP_FWD) || (op_sel == OP_INV)) && (key_len != KL_BAD);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Configuration captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_q    <= 1'b0;
            keygen_q <= 1'b0;
            klen_q   <= KL_128;
        end else if (cfg_load) begin
            inv_q    <= (op_sel == OP_INV);
            keygen_q <= keygen;
            klen_q   <= key_len;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d      = st_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        alert     = 1'b0;
        sb_en     = 1'b0;
        sb_ack    = 1'b0;
        kexp_en   = 1'b0;
        kexp_ack  = 1'b0;
        state_we  = 1'b0;
        state_sel = SSEL_ROUND;
        fkey_we   = 1'b0;
        fkey_sel  = FK_EXPAND;
        dkey_we   = 1'b0;
        prng_upd  = 1'b0;
        rnd_clr   = 1'b0;
        rnd_inc   = 1'b0;
        cfg_load  = 1'b0;
        step      = 1'b0;
        phase     = PH_MID;

        unique case (st_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                phase    = PH_FIRST;
                if (in_valid) begin
                    if (!cfg_ok) begin
                        st_d = ST_ERROR;
                    end else begin
                        cfg_load  = 1'b1;
                        prng_upd  = 1'b1;
                        rnd_clr   = 1'b1;
                        state_we  = !keygen;
                        state_sel = SSEL_INPUT;
                        fkey_we   = 1'b1;
                        fkey_sel  = (keygen || op_sel == OP_FWD) ? FK_ENC_INIT : FK_DEC_INIT;
                        st_d      = ST_INIT;
                    end
                end
            end

            ST_INIT: begin
                phase = PH_FIRST;
                if (klen_q == KL_256) begin
                    step = 1'b1;
                end else begin
                    kexp_en = 1'b1;
                    if (kexp_req) begin
                        kexp_ack = 1'b1;
                        fkey_we  = 1'b1;
                        step     = 1'b1;
                    end
                end
                if (step) begin
                    state_we = !keygen_q;
                    rnd_inc  = 1'b1;
                    prng_upd = 1'b1;
                    st_d     = ST_ROUND;
                end
            end

            ST_ROUND: begin
                phase   = PH_MID;
                sb_en   = !keygen_q;
                kexp_en = 1'b1;
                if (kexp_req && (keygen_q || sb_req)) begin
                    sb_ack   = !keygen_q;
                    kexp_ack = 1'b1;
                    fkey_we  = 1'b1;
                    state_we = !keygen_q;
                    rnd_inc  = 1'b1;
                    prng_upd = 1'b1;
                    if (at_last_mid) begin
                        if (keygen_q) begin
                            dkey_we = 1'b1;
                            st_d    = ST_IDLE;
                        end else begin
                            st_d    = ST_FINAL;
                        end
                    end
                end
            end

            ST_FINAL: begin
                phase     = PH_LAST;
                sb_en     = 1'b1;
                out_valid = sb_req;
                if (sb_req && out_ready) begin
                    sb_ack    = 1'b1;
                    state_we  = 1'b1;
                    state_sel = SSEL_CLEAR;
                    st_d      = ST_IDLE;
                end
            end

            ST_ERROR: begin
                alert = 1'b1;
            end

            default: begin
                st_d = ST_ERROR;
            end
        endcase

        if (sel_fault) begin
            in_ready  = 1'b0;
            out_valid = 1'b0;
            state_we  = 1'b0;
            fkey_we   = 1'b0;
            dkey_we   = 1'b0;
            sb_ack    = 1'b0;
            kexp_ack  = 1'b0;
            rnd_inc   = 1'b0;
            rnd_clr   = 1'b0;
            prng_upd  = 1'b0;
            cfg_load  = 1'b0;
            st_d      = ST_ERROR;
        end
    end
endmodule

// File: rtl/aes_round_seq.sv
module aes_round_seq
    import aes_seq_pkg::*;
#(
    parameter int RND_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       op_sel,
    input  logic [1:0]       key_len,
    input  logic             keygen,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             sb_en,
    input  logic             sb_req,
    output logic             sb_ack,
    output logic             kexp_en,
    input  logic             kexp_req,
    output logic             kexp_ack,
    output logic             kexp_inv,
    output logic [RND_W-1:0] kexp_round,
    output logic [1:0]       state_sel,
    output logic             state_we,
    output logic [1:0]       ark_sel,
    output logic [1:0]       fkey_sel,
    output logic             fkey_we,
    output logic             dkey_we,
    output logic [1:0]       kword_sel,
    output logic             rkey_mix,
    output logic             prng_upd,
    input  logic             sel_fault,
    output logic             alert
);
    state_src_e ssel;
    fkey_src_e  fsel;
    ark_src_e   ark;
    kword_e     kword;
    phase_e     phase;
    logic       rnd_clr, rnd_inc, at_last_mid;
    logic       inv_q, keygen_q;
    logic [1:0] klen_q;

    aes_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_sel     (op_sel),
        .key_len    (key_len),
        .keygen     (keygen),
        .out_ready  (out_ready),
        .sb_req     (sb_req),
        .kexp_req   (kexp_req),
        .sel_fault  (sel_fault),
        .at_last_mid(at_last_mid),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .alert      (alert),
        .sb_en      (sb_en),
        .sb_ack     (sb_ack),
        .kexp_en    (kexp_en),
        .kexp_ack   (kexp_ack),
        .state_we   (state_we),
        .state_sel  (ssel),
        .fkey_we    (fkey_we),
        .fkey_sel   (fsel),
        .dkey_we    (dkey_we),
        .prng_upd   (prng_upd),
        .rnd_clr    (rnd_clr),
        .rnd_inc    (rnd_inc),
        .phase      (phase),
        .inv_q      (inv_q),
        .keygen_q   (keygen_q),
        .klen_q     (klen_q)
    );

    aes_seq_rnd_ctr #(.RND_W(RND_W)) u_rnd (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (rnd_clr),
        .inc        (rnd_inc),
        .klen       (klen_q),
        .rnd        (kexp_round),
        .at_last_mid(at_last_mid)
    );

    aes_seq_sel_map u_map (
        .phase   (phase),
        .inv     (inv_q),
        .keygen  (keygen_q),
        .klen    (klen_q),
        .kword   (kword),
        .ark     (ark),
        .rkey_mix(rkey_mix)
    );

    assign state_sel = ssel;
    assign fkey_sel  = fsel;
    assign ark_sel   = ark;
    assign kword_sel = kword;
    assign kexp_inv  = inv_q && !keygen_q;
endmodule

// File: rtl/aes_round_seq_chk.sv
module aes_round_seq_chk #(
    parameter int RND_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       op_sel,
    input logic [1:0]       key_len,
    input logic             keygen,
    input logic             out_valid,
    input logic             out_ready,
    input logic             sb_en,
    input logic             sb_req,
    input logic             sb_ack,
    input logic             kexp_en,
    input logic             kexp_req,
    input logic             kexp_ack,
    input logic             kexp_inv,
    input logic [RND_W-1:0] kexp_round,
    input logic [1:0]       state_sel,
    input logic             state_we,
    input logic [1:0]       ark_sel,
    input logic [1:0]       fkey_sel,
    input logic             fkey_we,
    input logic             dkey_we,
    input logic [1:0]       kword_sel,
    input logic             rkey_mix,
    input logic             prng_upd,
    input logic             sel_fault,
    input logic             alert
);
    a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    a_r2_final_no_round_write: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(state_we && state_sel == 2'd1));

    a_r4_mix_middle_only: assert property (@(posedge clk) disable iff (!rst_n)
        rkey_mix |-> ark_sel == 2'd1);

    a_r6_sb_ack_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        sb_ack |-> sb_en && sb_req);

    a_r6_kexp_ack_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        kexp_ack |-> kexp_en && kexp_req);

    a_r7_wipe_on_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |-> state_we && state_sel == 2'd2);

    a_r8_dkey_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        dkey_we |=> in_ready || sel_fault);

    a_r10_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fault |-> !out_valid && !state_we && !fkey_we && !dkey_we && !in_ready);

    a_r10_fault_locks: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fault |=> alert);

    a_r10_alert_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        alert |=> alert && !in_ready && !out_valid);
endmodule

bind aes_round_seq aes_round_seq_chk #(.RND_W(RND_W)) u_chk (.*);

// File: tb/test_aes_round_seq.sv
module test_aes_round_seq;
    localparam int RND_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic in_valid = 1'b0;
    logic [1:0] op_sel = 2'b01;
    logic [1:0] key_len = 2'd0;
    logic keygen = 1'b0;
    logic sel_fault = 1'b0;
    logic out_ready, sb_req, kexp_req;
    logic in_ready, out_valid, sb_en, sb_ack, kexp_en, kexp_ack, kexp_inv;
    logic [RND_W-1:0] kexp_round;
    logic [1:0] state_sel, ark_sel, fkey_sel, kword_sel;
    logic state_we, fkey_we, dkey_we, rkey_mix, prng_upd, alert;

    aes_round_seq #(.RND_W(RND_W)) i_aes_round_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_sel(op_sel), .key_len(key_len), .keygen(keygen),
        .out_valid(out_valid), .out_ready(out_ready),
        .sb_en(sb_en), .sb_req(sb_req), .sb_ack(sb_ack),
        .kexp_en(kexp_en), .kexp_req(kexp_req), .kexp_ack(kexp_ack),
        .kexp_inv(kexp_inv), .kexp_round(kexp_round),
        .state_sel(state_sel), .state_we(state_we), .ark_sel(ark_sel),
        .fkey_sel(fkey_sel), .fkey_we(fkey_we), .dkey_we(dkey_we),
        .kword_sel(kword_sel), .rkey_mix(rkey_mix), .prng_upd(prng_upd),
        .sel_fault(sel_fault), .alert(alert)
    );

    int checks = 0;
    int fails  = 0;
    int sb_lat = 1, ke_lat = 1, rdy_delay = 0;
    int sb_cnt, ke_cnt, v_cnt;
    int done_cnt = 0;

    // Datapath stubs: request after a programmable latency, hold until acknowledged
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sb_cnt <= 0; ke_cnt <= 0; v_cnt <= 0;
        end else begin
            sb_cnt <= (!sb_en || sb_ack) ? 0 : sb_cnt + 1;
            ke_cnt <= (!kexp_en || kexp_ack) ? 0 : ke_cnt + 1;
            v_cnt  <= (out_valid && !out_ready) ? v_cnt + 1 : 0;
        end
    end
    assign sb_req    = sb_en && (sb_cnt >= sb_lat - 1);
    assign kexp_req  = kexp_en && (ke_cnt >= ke_lat - 1);
    assign out_ready = (v_cnt >= rdy_delay);

    typedef struct {
        int n_init_w, n_mid_w, n_mix, n_fkey, n_dkey, n_prng, vcyc;
        int init_kw, mid_kw, fin_kw, fk_first, wiped, kg;
    } rec_t;

    rec_t exp_q[$];
    rec_t obs;
    bit   active = 0;

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic rec_t exp_for(input int kl, input bit inv, input bit kg, input int rd);
        rec_t e;
        int n;
        n = (kl == 1) ? 12 : (kl == 2) ? 14 : 10;
        e.kg       = kg;
        e.n_fkey   = 1 + ((kl == 2) ? 0 : 1) + (n - 1);
        e.n_prng   = n + 1;
        e.init_kw  = (!inv || kl == 0) ? 0 : (kl == 1) ? 1 : 2;
        e.mid_kw   = (kl == 0 || inv) ? 0 : (kl == 1) ? 1 : 2;
        e.fin_kw   = e.mid_kw;
        e.fk_first = (inv && !kg) ? 1 : 0;
        if (kg) begin
            e.n_init_w = 0; e.n_mid_w = 0; e.n_mix = 0; e.n_dkey = 1;
            e.vcyc = 0; e.mid_kw = 3; e.wiped = 0; e.fk_first = 0;
        end else begin
            e.n_init_w = 1; e.n_mid_w = n - 1; e.n_mix = inv ? n - 1 : 0;
            e.n_dkey = 0; e.vcyc = rd + 1; e.wiped = 1;
        end
        return e;
    endfunction

    task automatic compare_rec();
        rec_t e;
        if (exp_q.size() == 0) begin
            chk("R2 unexpected completion", 1, 0);
            return;
        end
        e = exp_q.pop_front();
        chk("R2 initial-step writes", obs.n_init_w, e.n_init_w);
        chk("R2 R6 middle-round writes", obs.n_mid_w, e.n_mid_w);
        chk("R4 mixed round keys", obs.n_mix, e.n_mix);
        chk("R5 full-key writes", obs.n_fkey, e.n_fkey);
        chk("R8 decryption-key writes", obs.n_dkey, e.n_dkey);
        chk("R11 prng updates", obs.n_prng, e.n_prng);
        chk("R7 R8 valid cycles", obs.vcyc, e.vcyc);
        chk("R3 middle key words", obs.mid_kw, e.mid_kw);
        chk("R12 first key source", obs.fk_first, e.fk_first);
        chk("R7 wipe at transfer", obs.wiped, e.wiped);
        if (!e.kg) begin
            chk("R3 initial key words", obs.init_kw, e.init_kw);
            chk("R3 final key words", obs.fin_kw, e.fin_kw);
        end
    endtask

    // Monitor: samples at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            active = 0;
        end else begin
            if (in_valid && in_ready) begin
                obs = '{default: 0};
                obs.init_kw = -1; obs.mid_kw = -1; obs.fin_kw = -1;
                obs.fk_first = fkey_sel;
                active = 1;
            end
            if (active) begin
                if (state_we && state_sel == 2'd1 && ark_sel == 2'd0) begin
                    obs.n_init_w++; obs.init_kw = kword_sel;
                end
                if (state_we && state_sel == 2'd1 && ark_sel == 2'd1) begin
                    obs.n_mid_w++; obs.mid_kw = kword_sel;
                end
                if (kexp_ack && ark_sel == 2'd1) obs.mid_kw = kword_sel;
                if (state_we && rkey_mix) obs.n_mix++;
                if (fkey_we) obs.n_fkey++;
                if (dkey_we) obs.n_dkey++;
                if (prng_upd) obs.n_prng++;
                if (out_valid) begin
                    obs.vcyc++; obs.fin_kw = kword_sel;
                end
                if (out_valid && out_ready) begin
                    obs.wiped = (state_we && state_sel == 2'd2) ? 1 : 0;
                    compare_rec();
                    active = 0;
                    done_cnt++;
                end else if (dkey_we) begin
                    compare_rec();
                    active = 0;
                    done_cnt++;
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; sel_fault = 1'b0;
        op_sel = 2'b01; key_len = 2'd0; keygen = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    // Driver: push expectation, offer the block, wait for the monitor
    task automatic run_op(input int kl, input bit inv, input bit kg,
                          input int sbl, input int kel, input int rd, input bit scramble);
        int target;
        target = done_cnt + 1;
        exp_q.push_back(exp_for(kl, inv, kg, rd));
        sb_lat = sbl; ke_lat = kel; rdy_delay = rd;
        key_len = kl[1:0]; op_sel = inv ? 2'b10 : 2'b01; keygen = kg; in_valid = 1'b1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #2 in_valid = 1'b0;
        if (scramble) begin
            op_sel = 2'b11; key_len = 2'd3; keygen = ~kg;
        end
        @(negedge clk);
        chk("R1 ready low while busy", in_ready, 0);
        wait (done_cnt >= target);
        @(posedge clk);
        #2;
    endtask

    task automatic final_report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: run did not complete");
        final_report();
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R1 reset in_ready", in_ready, 1);
        chk("R1 reset out_valid", out_valid, 0);
        chk("R1 reset alert", alert, 0);
        chk("R1 reset state_we", state_we, 0);
        @(posedge clk); #2;

        run_op(0, 0, 0, 1, 1, 0, 0);
        run_op(0, 1, 0, 5, 2, 3, 0);
        run_op(1, 0, 0, 5, 1, 0, 0);
        run_op(1, 1, 0, 1, 3, 2, 0);
        run_op(2, 0, 0, 5, 1, 1, 0);
        run_op(2, 1, 0, 1, 1, 0, 1);   // R9 config held while busy
        run_op(0, 0, 1, 1, 1, 0, 0);
        run_op(1, 1, 1, 5, 2, 0, 0);
        run_op(2, 0, 1, 1, 2, 0, 0);
        run_op(0, 1, 0, 5, 1, 4, 0);
        chk("R2 all expectations consumed", exp_q.size(), 0);

        // R9: illegal operation encoding
        op_sel = 2'b11; in_valid = 1'b1;
        @(negedge clk);
        chk("R9 no write on bad op", state_we || fkey_we, 0);
        @(posedge clk); #2 in_valid = 1'b0; op_sel = 2'b01;
        @(negedge clk);
        chk("R9 alert on bad op", alert, 1);
        chk("R9 not ready after bad op", in_ready, 0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R10 alert sticky", alert, 1);
        do_reset();

        // R9: illegal key length
        key_len = 2'd3; in_valid = 1'b1;
        @(posedge clk); #2 in_valid = 1'b0; key_len = 2'd0;
        @(negedge clk);
        chk("R9 alert on bad key length", alert, 1);
        do_reset();

        // R10: fault while the final result is waiting
        sb_lat = 1; ke_lat = 1; rdy_delay = 100;
        in_valid = 1'b1;
        @(posedge clk); #2 in_valid = 1'b0;
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        @(posedge clk); #2 sel_fault = 1'b1;
        @(negedge clk);
        chk("R10 valid dropped in fault cycle", out_valid, 0);
        chk("R10 no state write in fault cycle", state_we, 0);
        @(posedge clk); #2 sel_fault = 1'b0;
        @(negedge clk);
        chk("R10 alert after fault", alert, 1);
        chk("R10 valid stays low", out_valid, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 not ready in error", in_ready, 0);
        do_reset();

        // R10: fault in idle
        @(posedge clk); #2 sel_fault = 1'b1;
        @(negedge clk);
        chk("R10 idle ready gated by fault", in_ready, 0);
        @(posedge clk); #2 sel_fault = 1'b0;
        @(negedge clk);
        chk("R10 idle fault alert", alert, 1);
        do_reset();
        @(negedge clk);
        chk("R1 reset clears alert", alert, 0);

        final_report();
    end
endmodule